// File: doc/BRIEF.md
# Transmit Replay FIFO

This block is a byte-wide transmit buffer that sits between a DMA engine, which writes frame bytes, and a MAC transmitter, which pops them. Each stored byte carries an end-of-frame marker. The MAC side starts popping a frame when either of two things happens first: the count of unpopped bytes goes above a programmable threshold, or a complete frame (end marker written) is waiting.

While a frame is being sent, the block keeps the frame's bytes reserved so that a collision retry from the MAC can rewind the read pointer to the frame's first byte. That reservation ends, and the space goes back to the writer, once more than `REL_BYTES` bytes (default 96) of the frame have been popped. A late-collision flag also ends the reservation. A retry that arrives after the reservation has ended cannot be replayed. In that case the block drops the rest of the frame internally and reports a collision-abort status.

A software flush empties the buffer and resets its pointers in the same cycle, even in the middle of a frame. A frame that the MAC had partly read is aborted with an underflow pulse. The block then returns one status word for every frame it discarded, and holds the writer off until the last of those words has been accepted.

Top module: `tx_replay_fifo`

## Requirements
- R1: After reset, rd_valid, st_valid, flush_busy and rd_abort are 0 and wr_ready is 1.
- R2: A frame whose end marker has not yet been written becomes poppable (rd_valid=1) as soon as the count of unpopped bytes is strictly greater than fill_thresh. It is not poppable before that.
- R3: A frame whose end marker has been written is poppable even when its length does not exceed fill_thresh.
- R4: Bytes leave in write order. rd_last is 1 exactly on the byte that was written with wr_last=1.
- R5: A mac_retry during a frame, after at least one pop and with no more than REL_BYTES popped, rewinds the read side. The next byte presented is the frame's first byte, and the whole frame is then replayed.
- R6: The space of the frame in flight stays reserved, so wr_ready stays 0 when the buffer is full, up to and including the REL_BYTES-th pop. After pop number REL_BYTES+1 that space is freed and wr_ready returns to 1.
- R7: A mac_retry after the reservation has ended produces a status word with st_coll_abort=1 (st_flushed=0, st_underflow=0) and no replay. The frame's remaining bytes are discarded without rd_valid, and the next frame starts cleanly.
- R8: A mac_late_col during a frame ends that frame's reservation. A later retry in the same frame is handled as in R7.
- R9: flush_req clears the buffer on its clock edge. From the next cycle rd_valid is 0, and rd_abort pulses for one cycle if the flushed frame had been partly popped.
- R10: wr_ready is 0 while flush_busy is 1.
- R11: A flush produces one status word per discarded frame, including a partly written one. Every such word has st_flushed=1. Only the first word has st_underflow=1, and only when a frame had been partly popped. A pending status word holds stable until st_ready.
- R12: flush_busy stays 1 until every flush status word has been accepted through st_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write side offers a byte |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Byte ends its frame |
| wr_ready | output | 1 | Space available and no flush running |
| fill_thresh | input | $clog2(DEPTH)+1 | Start level for frames without end marker |
| rd_valid | output | 1 | Byte available to the MAC |
| rd_data | output | 8 | Byte toward the MAC |
| rd_last | output | 1 | Presented byte ends its frame |
| rd_ready | input | 1 | MAC takes the byte |
| rd_abort | output | 1 | One-cycle underflow pulse on a flush mid-frame |
| mac_retry | input | 1 | MAC requests a replay of the current frame |
| mac_late_col | input | 1 | MAC saw a late collision in the current frame |
| flush_req | input | 1 | Software flush command |
| flush_busy | output | 1 | Flush status words still outstanding |
| st_valid | output | 1 | Status word pending |
| st_ready | input | 1 | Status word accepted |
| st_underflow | output | 1 | Status: frame aborted mid-transfer |
| st_flushed | output | 1 | Status: frame discarded by flush |
| st_coll_abort | output | 1 | Status: retry refused after release |

## Verification
rd_valid is decoded without a register from the pointers, so it is due in the same cycle as the write or pop edge that changes the level. The bench samples it at the falling edge that follows. wr_ready frees one edge after the releasing pop, and rd_abort and a collision-abort status appear one edge after the flush or retry. The first flush status word comes one edge after that. Every check samples at the falling edge just after the edge named, and flush status words are counted in a loop that runs until flush_busy drops, so the exact pacing of the words does not matter.

// File: rtl/txf_pkg.sv
package txf_pkg;
   typedef struct packed {
      logic       last;
      logic [7:0] data;
   } txf_word_t;

   typedef struct packed {
      logic coll_abort;
      logic flushed;
      logic underflow;
   } txf_stat_t;
endpackage

// File: rtl/txf_mem.sv
module txf_mem
   import txf_pkg::*;
#(
   parameter int DEPTH = 2048,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  txf_word_t     wdata,
   input  logic [AW-1:0] raddr,
   output txf_word_t     rdata
);
   txf_word_t cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/txf_rd_ctl.sv
module txf_rd_ctl #(
   parameter int PW        = 12,
   parameter int REL_BYTES = 96,
   localparam int CW = $clog2(REL_BYTES + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [PW-1:0] wp,
   input  logic [PW-1:0] thresh,
   input  logic          has_full,
   input  logic          head_last,
   input  logic          rd_ready,
   input  logic          mac_retry,
   input  logic          mac_late_col,
   output logic          rd_valid,
   output logic          pop,
   output logic          pop_last,
   output logic [PW-1:0] rp,
   output logic [PW-1:0] base,
   output logic          active,
   output logic          coll_req
);
   logic [PW-1:0] rp_q, sp_q;
   logic [CW-1:0] cnt_q;
   logic          begun_q, drop_q, late_q;
   logic [PW-1:0] level;
   logic          go, hold, retry_ok, rewind;

   assign level    = wp - rp_q;
   assign go       = begun_q | has_full | (level > thresh);
   assign rd_valid = go & (level != '0) & ~drop_q;
   assign hold     = (cnt_q <= CW'(REL_BYTES)) & ~late_q;
   assign retry_ok = mac_retry & begun_q & ~drop_q;
   assign rewind   = retry_ok & hold;
   assign coll_req = retry_ok & ~hold;
   assign pop      = (level != '0) & ~retry_ok & (drop_q | (rd_valid & rd_ready));
   assign pop_last = pop & head_last;
   assign rp       = rp_q;
   assign base     = hold ? sp_q : rp_q;
   assign active   = begun_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rp_q    <= '0;
         sp_q    <= '0;
         cnt_q   <= '0;
         begun_q <= 1'b0;
         drop_q  <= 1'b0;
         late_q  <= 1'b0;
      end else begin
         if (mac_late_col && begun_q) late_q <= 1'b1;
         if (rewind) begin
            rp_q  <= sp_q;
            cnt_q <= '0;
         end else if (coll_req) begin
            drop_q <= 1'b1;
         end else if (pop) begin
            rp_q <= rp_q + PW'(1);
            if (head_last) begin
               sp_q    <= rp_q + PW'(1);
               cnt_q   <= '0;
               begun_q <= 1'b0;
               drop_q  <= 1'b0;
               late_q  <= 1'b0;
            end else begin
               begun_q <= 1'b1;
               if (cnt_q <= CW'(REL_BYTES)) cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   AST_REWIND_TO_START: assert property (@(posedge clk) disable iff (!rst_n || flush)
      rewind |=> (rp_q == $past(sp_q)));  // R5
   AST_NO_LATE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n || flush)
      coll_req |=> (drop_q && !rd_valid));  // R7
   AST_LATE_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n || flush)
      (mac_late_col && begun_q && !pop_last) |=> (base == rp_q));  // R8
endmodule

// File: rtl/txf_status.sv
module txf_status
   import txf_pkg::*;
#(
   parameter int NW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_req,
   input  logic [NW-1:0] n_frames,
   input  logic          active,
   input  logic          coll_req,
   input  logic          st_ready,
   output logic          st_valid,
   output txf_stat_t     st,
   output logic          flush_busy,
   output logic          flush_go,
   output logic          rd_abort
);
   logic          busy_q, vld_q, uf_first_q, abort_q;
   logic [NW-1:0] remain_q;
   txf_stat_t     st_q;
   logic          free;

   assign flush_go   = flush_req & ~busy_q;
   assign free       = ~vld_q | st_ready;
   assign st_valid   = vld_q;
   assign st         = st_q;
   assign flush_busy = busy_q;
   assign rd_abort   = abort_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         vld_q      <= 1'b0;
         uf_first_q <= 1'b0;
         abort_q    <= 1'b0;
         remain_q   <= '0;
         st_q       <= '0;
      end else begin
         abort_q <= flush_go & active;
         if (vld_q && st_ready) vld_q <= 1'b0;
         if (flush_go) begin
            busy_q     <= 1'b1;
            remain_q   <= n_frames;
            uf_first_q <= active;
         end else if (busy_q) begin
            if (free && remain_q != '0) begin
               vld_q           <= 1'b1;
               st_q.coll_abort <= 1'b0;
               st_q.flushed    <= 1'b1;
               st_q.underflow  <= uf_first_q;
               uf_first_q      <= 1'b0;
               remain_q        <= remain_q - NW'(1);
            end else if (!vld_q && remain_q == '0) begin
               busy_q <= 1'b0;
            end
         end else if (coll_req && free) begin
            vld_q           <= 1'b1;
            st_q.coll_abort <= 1'b1;
            st_q.flushed    <= 1'b0;
            st_q.underflow  <= 1'b0;
         end
      end
   end

   AST_ST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !st_ready) |=> (vld_q && $stable(st_q)));  // R11
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && vld_q) |=> busy_q);  // R12
endmodule

// File: rtl/tx_replay_fifo.sv
module tx_replay_fifo
   import txf_pkg::*;
#(
   parameter int DEPTH     = 2048,
   parameter int REL_BYTES = 96,
   localparam int AW = $clog2(DEPTH),
   localparam int PW = AW + 1,
   localparam int NW = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [7:0]    wr_data,
   input  logic          wr_last,
   output logic          wr_ready,
   input  logic [PW-1:0] fill_thresh,
   output logic          rd_valid,
   output logic [7:0]    rd_data,
   output logic          rd_last,
   input  logic          rd_ready,
   output logic          rd_abort,
   input  logic          mac_retry,
   input  logic          mac_late_col,
   input  logic          flush_req,
   output logic          flush_busy,
   output logic          st_valid,
   input  logic          st_ready,
   output logic          st_underflow,
   output logic          st_flushed,
   output logic          st_coll_abort
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 4");
   end
   if (REL_BYTES < 1 || REL_BYTES >= DEPTH) begin : g_bad_rel
      $error("REL_BYTES must lie in 1..DEPTH-1");
   end

   logic [PW-1:0] wp_q, nfull_q, rp, base, used;
   logic          wpart_q, wr_fire, pop, pop_last, active, coll_req, flush_go;
   logic [NW-1:0] n_frames;
   txf_word_t     wword, rword;
   txf_stat_t     st;

   assign used     = wp_q - base;
   assign wr_ready = ~flush_busy & ~flush_req & (used < PW'(DEPTH));
   assign wr_fire  = wr_valid & wr_ready;
   assign wword    = '{last: wr_last, data: wr_data};
   assign n_frames = {1'b0, nfull_q} + NW'(wpart_q);
   assign rd_data  = rword.data;
   assign rd_last  = rword.last;
   assign st_underflow  = st.underflow;
   assign st_flushed    = st.flushed;
   assign st_coll_abort = st.coll_abort;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_go) begin
         wp_q    <= '0;
         nfull_q <= '0;
         wpart_q <= 1'b0;
      end else begin
         if (wr_fire) begin
            wp_q    <= wp_q + PW'(1);
            wpart_q <= ~wr_last;
         end
         nfull_q <= nfull_q + PW'(wr_fire & wr_last) - PW'(pop_last);
      end
   end

   txf_mem #(.DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (wr_fire),
      .waddr (wp_q[AW-1:0]),
      .wdata (wword),
      .raddr (rp[AW-1:0]),
      .rdata (rword)
   );

   txf_rd_ctl #(.PW(PW), .REL_BYTES(REL_BYTES)) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush_go),
      .wp           (wp_q),
      .thresh       (fill_thresh),
      .has_full     (nfull_q != '0),
      .head_last    (rword.last),
      .rd_ready     (rd_ready),
      .mac_retry    (mac_retry),
      .mac_late_col (mac_late_col),
      .rd_valid     (rd_valid),
      .pop          (pop),
      .pop_last     (pop_last),
      .rp           (rp),
      .base         (base),
      .active       (active),
      .coll_req     (coll_req)
   );

   txf_status #(.NW(NW)) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_req  (flush_req),
      .n_frames   (n_frames),
      .active     (active),
      .coll_req   (coll_req),
      .st_ready   (st_ready),
      .st_valid   (st_valid),
      .st         (st),
      .flush_busy (flush_busy),
      .flush_go   (flush_go),
      .rd_abort   (rd_abort)
   );

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_go |=> (!rd_valid && wp_q == rp));  // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH));  // R6
   AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (wp_q != rp));  // R4
endmodule

// File: tb/tx_replay_fifo_bench.sv
module tx_replay_fifo_bench;
   localparam int DEPTH = 128;
   localparam int PW = $clog2(DEPTH) + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_valid = 0, wr_last = 0, rd_ready = 0, mac_retry = 0, mac_late_col = 0;
   logic flush_req = 0, st_ready = 0;
   logic [7:0] wr_data = '0;
   logic [PW-1:0] fill_thresh = '0;
   logic wr_ready, rd_valid, rd_last, rd_abort, flush_busy, st_valid;
   logic st_underflow, st_flushed, st_coll_abort;
   logic [7:0] rd_data;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   tx_replay_fifo #(.DEPTH(DEPTH)) u_tx_replay_fifo (.*);

   // {fill_thresh, frame length}
   localparam int TAB [6][2] = '{'{10, 3}, '{2, 5}, '{0, 1}, '{8, 8}, '{4, 12}, '{1, 2}};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d, input logic l);
      wr_valid = 1; wr_data = d; wr_last = l;
      @(negedge clk);
      wr_valid = 0; wr_last = 0;
   endtask

   task automatic pop_chk(input logic [7:0] d, input logic l, input string req);
      chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
      chk(rd_data === d, req, int'(rd_data), int'(d));
      chk(rd_last === l, req, int'(rd_last), int'(l));
      rd_ready = 1;
      @(negedge clk);
      rd_ready = 0;
   endtask

   task automatic pulse(ref logic s);
      s = 1;
      @(negedge clk);
      s = 0;
   endtask

   task automatic drain(output int n, output int nu, output int nbad);
      n = 0; nu = 0; nbad = 0;
      st_ready = 1;
      for (int k = 0; k < 40; k++) begin
         if (st_valid) begin
            n++;
            if (st_underflow) nu++;
            if (!st_flushed || st_coll_abort) nbad++;
         end
         @(negedge clk);
         if (!flush_busy) break;
      end
      st_ready = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      int n, nu, nbad;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(rd_valid == 0 && st_valid == 0 && flush_busy == 0 && rd_abort == 0, "R1", int'(rd_valid), 0);
      chk(wr_ready == 1, "R1", int'(wr_ready), 1);

      // R2 R3 R4: table of thresholds and frame lengths
      for (int e = 0; e < 6; e++) begin
         fill_thresh = PW'(TAB[e][0]);
         for (int k = 1; k <= TAB[e][1]; k++) begin
            wr(8'(e * 16 + k - 1), k == TAB[e][1]);
            chk(rd_valid == ((k > TAB[e][0]) || (k == TAB[e][1])),
                (k == TAB[e][1]) ? "R3" : "R2", int'(rd_valid),
                int'((k > TAB[e][0]) || (k == TAB[e][1])));
         end
         for (int k = 0; k < TAB[e][1]; k++)
            pop_chk(8'(e * 16 + k), k == TAB[e][1] - 1, "R4");
         chk(rd_valid == 0, "R4", int'(rd_valid), 0);
      end

      // R5 rewind before the release point
      fill_thresh = 0;
      for (int k = 0; k < 10; k++) wr(8'(8'h30 + k), k == 9);
      for (int k = 0; k < 4; k++) pop_chk(8'(8'h30 + k), 0, "R5");
      pulse(mac_retry);
      for (int k = 0; k < 10; k++) pop_chk(8'(8'h30 + k), k == 9, "R5");
      chk(st_valid == 0, "R5", int'(st_valid), 0);

      // R6 R7 reservation release and refused retry
      for (int k = 0; k < DEPTH; k++) wr(8'(k), k == DEPTH - 1);
      chk(wr_ready == 0, "R6", int'(wr_ready), 0);
      for (int k = 0; k < 96; k++) pop_chk(8'(k), 0, "R6");
      chk(wr_ready == 0, "R6", int'(wr_ready), 0);
      pop_chk(8'd96, 0, "R6");
      chk(wr_ready == 1, "R6", int'(wr_ready), 1);
      pulse(mac_retry);
      chk(st_valid == 1 && st_coll_abort == 1, "R7", int'(st_coll_abort), 1);
      chk(st_flushed == 0 && st_underflow == 0, "R7", int'(st_flushed), 0);
      chk(rd_valid == 0, "R7", int'(rd_valid), 0);
      repeat (40) @(negedge clk);
      chk(rd_valid == 0, "R7", int'(rd_valid), 0);
      pulse(st_ready);
      chk(st_valid == 0, "R7", int'(st_valid), 0);
      for (int k = 0; k < 3; k++) wr(8'(8'h55 + k), k == 2);
      for (int k = 0; k < 3; k++) pop_chk(8'(8'h55 + k), k == 2, "R7");

      // R8 late collision blocks replay
      for (int k = 0; k < 10; k++) wr(8'(8'h40 + k), k == 9);
      for (int k = 0; k < 3; k++) pop_chk(8'(8'h40 + k), 0, "R8");
      pulse(mac_late_col);
      pop_chk(8'h43, 0, "R8");
      pulse(mac_retry);
      chk(st_valid == 1 && st_coll_abort == 1, "R8", int'(st_coll_abort), 1);
      repeat (15) @(negedge clk);
      chk(rd_valid == 0, "R8", int'(rd_valid), 0);
      pulse(st_ready);

      // R9 R10 R11 R12 flush with a frame partly popped
      for (int k = 0; k < 5; k++) wr(8'(8'hA0 + k), k == 4);
      for (int k = 0; k < 4; k++) wr(8'(8'hB0 + k), k == 3);
      for (int k = 0; k < 2; k++) wr(8'(8'hC0 + k), 0);
      pop_chk(8'hA0, 0, "R9");
      pop_chk(8'hA1, 0, "R9");
      pulse(flush_req);
      chk(rd_valid == 0, "R9", int'(rd_valid), 0);
      chk(rd_abort == 1, "R9", int'(rd_abort), 1);
      chk(flush_busy == 1 && wr_ready == 0, "R10", int'(wr_ready), 0);
      @(negedge clk);
      chk(rd_abort == 0, "R9", int'(rd_abort), 0);
      chk(st_valid == 1 && st_underflow == 1 && st_flushed == 1, "R11", int'(st_underflow), 1);
      repeat (3) @(negedge clk);
      chk(flush_busy == 1 && st_valid == 1, "R12", int'(flush_busy), 1);
      chk(wr_ready == 0, "R10", int'(wr_ready), 0);
      drain(n, nu, nbad);
      chk(n == 3, "R11", n, 3);
      chk(nu == 1, "R11", nu, 1);
      chk(nbad == 0, "R11", nbad, 0);
      chk(flush_busy == 0 && wr_ready == 1, "R12", int'(flush_busy), 0);
      chk(rd_valid == 0, "R9", int'(rd_valid), 0);

      // R11 flush with nothing popped: no underflow flag
      fill_thresh = 100;
      for (int k = 0; k < 3; k++) wr(8'(8'hD0 + k), k == 2);
      for (int k = 0; k < 3; k++) wr(8'(8'hE0 + k), k == 2);
      pulse(flush_req);
      chk(rd_abort == 0, "R9", int'(rd_abort), 0);
      drain(n, nu, nbad);
      chk(n == 2, "R11", n, 2);
      chk(nu == 0 && nbad == 0, "R11", nu, 0);
      chk(flush_busy == 0 && wr_ready == 1 && rd_valid == 0, "R12", int'(flush_busy), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule